// File: doc/BRIEF.md
# Two-Bank Edge and Level Interrupt Controller

This block collects up to 64 interrupt lines, grouped as two banks of 32, and merges them into one request to a processor. Each line passes through a synchronizer. A rising edge on the synchronized line is held in a per-source event bit until software clears it. The synchronized level is also visible directly. A source is pending when its enable bit is set and either its event bit or its live level is high. The logical OR of all pending sources, registered, drives the processor request. A registered index output gives the highest-numbered pending source. A second controller of the same kind can be chained by wiring its request output to any ordinary source input.

Software reaches the block through a plain register port of one cycle. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from the address while `bus_valid` is high and `bus_write` is low. There is no back-pressure: every access completes in the cycle it is presented. Each bank has four word registers: event, enable, acknowledge and level. The bank for the upper sources sits at the lower address.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is zero, and `cpu_irq` and `pend_valid` are low.
- R2: Byte address 0x20 holds the bank for sources 0 to 31 and address 0x10 holds the bank for sources 32 to 63. Within a bank, offset 0x0 is event, 0x4 is enable, 0x8 is acknowledge and 0xC is level. Source n uses bit n mod 32.
- R3: A rising edge of a synchronized source sets its event bit, whatever the enable bit holds.
- R4: Writing the acknowledge register clears every event bit written as one and leaves bits written as zero unchanged. A read of the acknowledge register returns zero.
- R5: When a rising edge and an acknowledge of the same bit occur in the same cycle, the event bit stays set.
- R6: The level register returns the synchronized state of each source line, whatever the enable bit holds.
- R7: A source is pending when (event OR level) AND enable is one for its bit. `cpu_irq` is the OR of all pending bits, registered one cycle.
- R8: Setting an enable bit while its line is already high does not set the event bit. The request then lasts only as long as the line stays high.
- R9: `pend_idx` names the highest-numbered pending source. Bank 1 is searched first, and within a bank the highest bit wins. `pend_valid` is low when nothing is pending and always equals `cpu_irq`.
- R10: A value written to an enable register is returned by a read in the next cycle.
- R11: Writes to event or level registers, to unmapped addresses (0x00 to 0x0F, 0x30 to 0x3F) or to addresses that are not word-aligned change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Raw source lines, bit n is source n |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address within the 0x40 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | 1 | Request to the processor |
| pend_valid | output | 1 | High when pend_idx is meaningful |
| pend_idx | output | 6 | Highest pending source number |

## Verification
Single pulses on lines with the enable bit clear separate edge capture from masking. Pulses held against an acknowledge show that zero bits in the written mask do nothing. One line is kept high across acknowledge and enable to separate the level term from the event term. A group of simultaneous pulses spread over both banks, acknowledged one at a time, checks the order of the search and the reversed bank addresses. One acknowledge is placed in the exact cycle of a rising edge to check which one wins.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, ev_q, en_q, clr_mask;

  assign rise_o   = lvl_i & ~prev_q;
  assign clr_mask = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ev_q   <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= lvl_i;
      // a new edge wins over an acknowledge of the same bit
      ev_q   <= (ev_q & ~clr_mask) | rise_o;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign ev_o   = ev_q;
  assign en_o   = en_q;
  assign pend_o = (ev_q | lvl_i) & en_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (vec_i[i]) idx_o = IDX_W'(i);
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6,
  localparam int NUM_SRC    = NUM_BANKS * BANK_W,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BANK_W-1:0]  bus_wdata,
  output logic [BANK_W-1:0]  bus_rdata,
  output logic               cpu_irq,
  output logic               pend_valid,
  output logic [IDX_W-1:0]   pend_idx
);
  localparam int SEL_W = ADDR_W - 4;

  logic [NUM_SRC-1:0] lvl_all, ev_all, en_all, rise_all, pend_vec;
  logic [NUM_BANKS-1:0] hit;
  reg_sel_e word_sel;
  logic aligned;
  logic any_pend;
  logic [IDX_W-1:0] top_idx;

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl_all)
  );

  assign word_sel = reg_sel_e'(bus_addr[3:2]);
  assign aligned  = (bus_addr[1:0] == 2'b00);

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      // lower-numbered banks sit at higher addresses
      localparam logic [SEL_W-1:0] SEL = SEL_W'(NUM_BANKS - b);
      logic en_we, ack_we;

      assign hit[b]  = bus_valid && aligned && (bus_addr[ADDR_W-1:4] == SEL);
      assign en_we   = hit[b] && bus_write && (word_sel == REG_ENABLE);
      assign ack_we  = hit[b] && bus_write && (word_sel == REG_ACK);

      irq_bank #(.W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_all[b*BANK_W +: BANK_W]),
        .en_we_i (en_we),
        .ack_we_i(ack_we),
        .wdata_i (bus_wdata),
        .ev_o    (ev_all[b*BANK_W +: BANK_W]),
        .en_o    (en_all[b*BANK_W +: BANK_W]),
        .rise_o  (rise_all[b*BANK_W +: BANK_W]),
        .pend_o  (pend_vec[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (hit[k] && !bus_write) begin
        case (word_sel)
          REG_EVENT:  bus_rdata = ev_all[k*BANK_W +: BANK_W];
          REG_ENABLE: bus_rdata = en_all[k*BANK_W +: BANK_W];
          REG_LEVEL:  bus_rdata = lvl_all[k*BANK_W +: BANK_W];
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .vec_i(pend_vec), .any_o(any_pend), .idx_o(top_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq    <= 1'b0;
      pend_valid <= 1'b0;
      pend_idx   <= '0;
    end else begin
      cpu_irq    <= |pend_vec;
      pend_valid <= any_pend;
      pend_idx   <= top_idx;
    end
  end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_SRC   = 64,
  parameter int IDX_W     = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BANK_W-1:0]  bus_wdata,
  input logic               cpu_irq,
  input logic               pend_valid,
  input logic [IDX_W-1:0]   pend_idx,
  input logic [NUM_SRC-1:0] ev_all,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] rise_all,
  input logic [NUM_SRC-1:0] pend_vec
);
  localparam logic [ADDR_W-1:0] EN0_ADDR  = ADDR_W'(NUM_BANKS * 16 + 4);
  localparam logic [ADDR_W-1:0] ACK0_ADDR = ADDR_W'(NUM_BANKS * 16 + 8);

  logic wr_en0, wr_ack0;
  assign wr_en0  = bus_valid && bus_write && (bus_addr == EN0_ADDR);
  assign wr_ack0 = bus_valid && bus_write && (bus_addr == ACK0_ADDR);

  // R1
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|en_all) |=> !cpu_irq);

  // R3
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_all) |=> ((ev_all & $past(rise_all)) == $past(rise_all)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack0 |=> ((ev_all[BANK_W-1:0] & $past(bus_wdata & ~rise_all[BANK_W-1:0])) == '0));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_vec) |=> cpu_irq);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_vec) |=> !cpu_irq);

  // R9
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == cpu_irq);

  // R9
  top_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (($past(pend_vec) >> pend_idx) == NUM_SRC'(1)));

  // R10
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en0 |=> (en_all[BANK_W-1:0] == $past(bus_wdata)));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cpu_irq(cpu_irq),
  .pend_valid(pend_valid), .pend_idx(pend_idx), .ev_all(ev_all),
  .en_all(en_all), .rise_all(rise_all), .pend_vec(pend_vec)
);

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] EV0 = 6'h20, EN0 = 6'h24, ACK0 = 6'h28, LV0 = 6'h2C;
  localparam logic [5:0] EV1 = 6'h10, EN1 = 6'h14, ACK1 = 6'h18, LV1 = 6'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, pend_valid;
  logic [5:0]  pend_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  banked_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .pend_valid(pend_valid),
    .pend_idx(pend_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] m);
    @(negedge clk); src_i = src_i | m;
    wait_cyc(4);
    src_i = src_i & ~m;
    wait_cyc(4);
  endtask

  task automatic clean();
    src_i = '0;
    bus_wr(EN0, '0); bus_wr(EN1, '0);
    wait_cyc(4);
    bus_wr(ACK0, '1); bus_wr(ACK1, '1);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", cpu_irq, 0);
    check("R1 valid", pend_valid, 0);
    bus_rd(EN0, d); check("R1 en0", d, 0);
    bus_rd(EN1, d); check("R1 en1", d, 0);
  endtask

  task automatic t_edge_level();
    logic [31:0] d;
    @(negedge clk); src_i[5] = 1'b1;
    wait_cyc(4);
    bus_rd(LV0, d); check("R6 level masked", d, 32'h20);
    check("R7 masked no irq", cpu_irq, 0);
    src_i[5] = 1'b0; wait_cyc(4);
    bus_rd(EV0, d); check("R3 event masked", d, 32'h20);
    bus_wr(EN0, 32'h20); wait_cyc(2);
    check("R7 irq from event", cpu_irq, 1);
    check("R9 idx 5", {pend_valid, pend_idx}, {1'b1, 6'd5});
    bus_wr(ACK0, 32'h20); wait_cyc(2);
    check("R7 irq after ack", cpu_irq, 0);
    check("R9 valid after ack", pend_valid, 0);
    clean();
  endtask

  task automatic t_ack_zero();
    logic [31:0] d;
    pulse(64'h220);
    bus_wr(ACK0, 32'h200);
    bus_rd(EV0, d); check("R4 zero bits kept", d, 32'h20);
    bus_rd(ACK0, d); check("R4 ack reads zero", d, 0);
    clean();
  endtask

  task automatic t_map();
    logic [31:0] d;
    pulse(64'h1 << 40);
    bus_rd(EV1, d); check("R2 bank1 event", d, 32'h100);
    bus_rd(EV0, d); check("R2 bank0 untouched", d, 0);
    @(negedge clk); src_i[63] = 1'b1; wait_cyc(4);
    bus_rd(LV1, d); check("R2 bank1 level bit31", d, 32'h8000_0000);
    clean();
  endtask

  task automatic t_priority();
    logic [63:0] m;
    m = (64'h1 << 3) | (64'h1 << 20) | (64'h1 << 33) | (64'h1 << 62);
    bus_wr(EN0, '1); bus_wr(EN1, '1);
    pulse(m);
    check("R9 top 62", {pend_valid, pend_idx}, {1'b1, 6'd62});
    bus_wr(ACK1, 32'h4000_0000); wait_cyc(2);
    check("R9 next 33", {pend_valid, pend_idx}, {1'b1, 6'd33});
    bus_wr(ACK1, 32'h2); wait_cyc(2);
    check("R9 next 20", {pend_valid, pend_idx}, {1'b1, 6'd20});
    bus_wr(ACK0, 32'h10_0000); wait_cyc(2);
    check("R9 next 3", {pend_valid, pend_idx}, {1'b1, 6'd3});
    bus_wr(ACK0, 32'h8); wait_cyc(2);
    check("R9 none", {cpu_irq, pend_valid}, 0);
    clean();
  endtask

  task automatic t_enable_high();
    logic [31:0] d;
    @(negedge clk); src_i[7] = 1'b1; wait_cyc(4);
    bus_wr(ACK0, 32'h80); wait_cyc(2);
    bus_wr(EN0, 32'h80); wait_cyc(3);
    bus_rd(EV0, d); check("R8 no event on enable", d, 0);
    check("R8 level request", {cpu_irq, pend_idx}, {1'b1, 6'd7});
    src_i[7] = 1'b0; wait_cyc(4);
    check("R8 request ends with line", cpu_irq, 0);
    clean();
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    pulse(64'h1000);
    @(negedge clk); src_i[12] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ACK0; bus_wdata = 32'h1000;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    bus_rd(EV0, d); check("R5 edge beats ack", d, 32'h1000);
    bus_wr(ACK0, 32'h1000);
    bus_rd(EV0, d); check("R4 ack while high", d, 0);
    clean();
  endtask

  task automatic t_readback_ignored();
    logic [31:0] d;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = EN1; bus_wdata = 32'h5A5A_0001;
    @(negedge clk);
    bus_write = 1'b0; bus_addr = EN1;
    #1 d = bus_rdata; bus_valid = 1'b0;
    check("R10 next cycle readback", d, 32'h5A5A_0001);
    bus_wr(EN1, '0);
    pulse(64'h200);
    bus_wr(EV0, '1); bus_wr(LV0, '1); bus_wr(6'h00, '1);
    bus_wr(6'h34, '1); bus_wr(6'h25, '1);
    bus_rd(EV0, d); check("R11 event kept", d, 32'h200);
    bus_rd(LV0, d); check("R11 level kept", d, 0);
    bus_rd(EN0, d); check("R11 enable kept", d, 0);
    bus_rd(6'h34, d); check("R11 unmapped reads zero", d, 0);
    check("R11 no irq", cpu_irq, 0);
    clean();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_edge_level();
    t_ack_zero();
    t_map();
    t_priority();
    t_enable_high();
    t_same_cycle();
    t_readback_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule